// File: doc/BRIEF.md
# Two-tier retention power-gating sequencer

This sequencer controls a power-gated CPU domain whose flip-flops each keep their state in two places. One store is fast but holds data only briefly. The other is slow to write but holds data for a long time. The sequencer accepts sleep and wake requests and drives five domain controls: the supply switch enable, a forced-discharge enable, the domain clock gate, an active-low retain/restore line and a strobe that moves state into the long-term store.

All timing runs on a tick at twice the domain clock rate, so half-cycle steps can be expressed exactly. Entering sleep drops the retain line, the supply switch and the clock gate together, so saving state adds no delay before the supply is cut. While the domain sleeps, a counter measures the elapsed ticks against a programmable limit. When the limit is reached, the sequencer discharges the virtual supply and then pulses the transfer strobe, so state reaches the long-term store before the short-term store expires. Waking restores the supply, waits for it to settle, opens the clock and only then releases the retain line.

Top module: `pg_retention_seq`

## Requirements
- R1: After reset, and in the powered state, the outputs are pwr_en_o=1, clk_en_o=1, retain_n_o=1, dis_en_o=0, lt_xfer_o=0 and busy_o=0, with all done pulses low. An asynchronous reset in any state returns the block to this state.
- R2: A sleep request sampled in the powered state makes retain_n_o, pwr_en_o and clk_en_o all fall at that same edge.
- R3: Power-down lasts 3 ticks with busy_o high. sleep_done_o pulses for one tick starting 3 ticks after the accepting edge, and the domain then stays off with busy_o low.
- R4: With limit_i nonzero, dis_en_o rises max(limit_i,3)+1 ticks after the sleep was accepted, provided the domain is still asleep. limit_i=0 disables the long-term transfer.
- R5: Discharge lasts max(dis_len_i,1) ticks. lt_xfer_o follows immediately for max(osg_len_i,1) ticks. xfer_done_o then pulses for one tick and the domain stays off. Neither dis_en_o nor lt_xfer_o is ever high while pwr_en_o is high.
- R6: A wake request sampled in an off state raises pwr_en_o at that edge. clk_en_o rises 2 ticks later and retain_n_o rises 4 ticks later. wake_done_o pulses 5 ticks later, when the powered state is reached. busy_o is high throughout.
- R7: A wake request arriving during power-down, discharge or transfer is held. It starts the wake-up one tick after that sequence completes. A wake request arriving on the edge at which discharge would start wins, and no transfer happens.
- R8: Sleep requests are ignored outside the powered state. Wake requests are ignored, and not held, in the powered state and during wake-up. When both requests arrive together in the powered state, the sleep request is taken.
- R9: Each done output is a single-tick pulse, and at most one done output is high in any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the domain clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to power the domain down |
| wake_req_i | input | 1 | Request to power the domain up |
| limit_i | input | TMR_W | Sleep ticks before the long-term transfer starts; 0 disables it |
| dis_len_i | input | LEN_W | Discharge phase length in ticks (0 treated as 1) |
| osg_len_i | input | LEN_W | Transfer strobe width in ticks (0 treated as 1) |
| pwr_en_o | output | 1 | Domain supply switch enable |
| dis_en_o | output | 1 | Forced discharge of the virtual supply |
| clk_en_o | output | 1 | Domain clock gate enable |
| retain_n_o | output | 1 | Active-low retain/restore line to the flip-flops |
| lt_xfer_o | output | 1 | Strobe moving state into the long-term store |
| busy_o | output | 1 | A sequence is in progress |
| sleep_done_o | output | 1 | One-tick pulse when power-down completes |
| xfer_done_o | output | 1 | One-tick pulse when the long-term transfer completes |
| wake_done_o | output | 1 | One-tick pulse when wake-up completes |

## Verification
The hardest cases to reach are wake requests that land on the exact boundary ticks of a sequence. Examples are the last tick of power-down, the tick on which discharge would begin, and the final tick of the transfer strobe. In each case a single tick of difference decides whether the request is held, wins, or is serviced later. Each table vector sets a limit, the two phase lengths and an absolute wake tick, chosen so that each of these boundaries is hit. An independent tick-by-tick model of the requirements gives the expected value of every output on every tick of the run.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;

  typedef enum logic [3:0] {
    ST_ON, ST_PD, ST_OFF, ST_DIS, ST_XFER, ST_LONG, ST_STAB, ST_CLK, ST_REST
  } pg_state_e;

  localparam int PD_TICKS   = 3;
  localparam int STAB_TICKS = 2;
  localparam int CLK_TICKS  = 2;
  localparam int REST_TICKS = 1;

  typedef struct packed {
    logic pwr;
    logic clk;
    logic ret_n;
    logic dis;
    logic xfer;
    logic busy;
  } pg_ctrl_t;

  function automatic pg_ctrl_t pg_decode(pg_state_e s);
    pg_ctrl_t c;
    c = '0;
    case (s)
      ST_ON:   begin c.pwr = 1'b1; c.clk = 1'b1; c.ret_n = 1'b1; end
      ST_PD:   c.busy = 1'b1;
      ST_DIS:  begin c.dis = 1'b1; c.busy = 1'b1; end
      ST_XFER: begin c.xfer = 1'b1; c.busy = 1'b1; end
      ST_STAB: begin c.pwr = 1'b1; c.busy = 1'b1; end
      ST_CLK:  begin c.pwr = 1'b1; c.clk = 1'b1; c.busy = 1'b1; end
      ST_REST: begin c.pwr = 1'b1; c.clk = 1'b1; c.ret_n = 1'b1; c.busy = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pg_step_cnt.sv
module pg_step_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_STEP_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX); // R5

endmodule

// File: rtl/pg_sleep_timer.sv
module pg_sleep_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  // cnt_q equals the ticks elapsed since the sleep was accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (start_i)                    cnt_q <= '0;
    else if (run_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (limit_i != '0) && (cnt_q >= limit_i);

  AST_TMR_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !start_i) |=> cnt_q == CNT_MAX); // R4

endmodule

// File: rtl/pg_retention_seq.sv
module pg_retention_seq
  import pg_seq_pkg::*;
#(
  parameter int TMR_W = 24,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             wake_req_i,
  input  logic [TMR_W-1:0] limit_i,
  input  logic [LEN_W-1:0] dis_len_i,
  input  logic [LEN_W-1:0] osg_len_i,
  output logic             pwr_en_o,
  output logic             dis_en_o,
  output logic             clk_en_o,
  output logic             retain_n_o,
  output logic             lt_xfer_o,
  output logic             busy_o,
  output logic             sleep_done_o,
  output logic             xfer_done_o,
  output logic             wake_done_o
);
  localparam int STEP_W = (LEN_W < 3) ? 3 : LEN_W;

  pg_state_e   state_q, state_d;
  logic [STEP_W-1:0] step_q;
  logic        tmr_hit, wake_pend_q, wake_go;
  logic        s_done, x_done, w_done;
  logic        s_done_q, x_done_q, w_done_q;
  logic [LEN_W-1:0] dis_last, xfer_last;
  pg_ctrl_t    ctrl;

  assign dis_last  = (dis_len_i == '0) ? '0 : dis_len_i - 1'b1;
  assign xfer_last = (osg_len_i == '0) ? '0 : osg_len_i - 1'b1;
  assign wake_go   = wake_req_i || wake_pend_q;

  pg_step_cnt #(.W(STEP_W)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .cnt_o  (step_q)
  );

  pg_sleep_timer #(.W(TMR_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (state_q == ST_ON && sleep_req_i),
    .run_i   (state_q == ST_PD || state_q == ST_OFF),
    .limit_i (limit_i),
    .hit_o   (tmr_hit)
  );

  always_comb begin
    state_d = state_q;
    s_done  = 1'b0;
    x_done  = 1'b0;
    w_done  = 1'b0;
    unique case (state_q)
      ST_ON:   if (sleep_req_i) state_d = ST_PD;
      ST_PD:   if (step_q == STEP_W'(PD_TICKS - 1)) begin
                 state_d = ST_OFF;
                 s_done  = 1'b1;
               end
      ST_OFF:  if (wake_go)      state_d = ST_STAB;
               else if (tmr_hit) state_d = ST_DIS;
      ST_DIS:  if (step_q == STEP_W'(dis_last)) state_d = ST_XFER;
      ST_XFER: if (step_q == STEP_W'(xfer_last)) begin
                 state_d = ST_LONG;
                 x_done  = 1'b1;
               end
      ST_LONG: if (wake_go) state_d = ST_STAB;
      ST_STAB: if (step_q == STEP_W'(STAB_TICKS - 1)) state_d = ST_CLK;
      ST_CLK:  if (step_q == STEP_W'(CLK_TICKS - 1))  state_d = ST_REST;
      ST_REST: if (step_q == STEP_W'(REST_TICKS - 1)) begin
                 state_d = ST_ON;
                 w_done  = 1'b1;
               end
      default: state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ON;
      wake_pend_q <= 1'b0;
      s_done_q    <= 1'b0;
      x_done_q    <= 1'b0;
      w_done_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      s_done_q <= s_done;
      x_done_q <= x_done;
      w_done_q <= w_done;
      if (state_d == ST_STAB)
        wake_pend_q <= 1'b0;
      else if (wake_req_i && (state_q inside {ST_PD, ST_DIS, ST_XFER}))
        wake_pend_q <= 1'b1;
    end
  end

  assign ctrl         = pg_decode(state_q);
  assign pwr_en_o     = ctrl.pwr;
  assign clk_en_o     = ctrl.clk;
  assign retain_n_o   = ctrl.ret_n;
  assign dis_en_o     = ctrl.dis;
  assign lt_xfer_o    = ctrl.xfer;
  assign busy_o       = ctrl.busy;
  assign sleep_done_o = s_done_q;
  assign xfer_done_o  = x_done_q;
  assign wake_done_o  = w_done_q;

  AST_ZERO_BACKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(retain_n_o) |-> (!pwr_en_o && !clk_en_o)); // R2
  AST_DIS_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_en_o || lt_xfer_o) |-> !pwr_en_o); // R5
  AST_XFER_AFTER_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lt_xfer_o) |-> $past(dis_en_o)); // R5
  AST_CLK_AFTER_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> $past(pwr_en_o)); // R6
  AST_RESTORE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retain_n_o) |-> ($past(clk_en_o) && pwr_en_o)); // R6
  AST_PEND_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_pend_q && (state_q == ST_OFF || state_q == ST_LONG)) |=> state_q == ST_STAB); // R7
  AST_DONE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sleep_done_o, xfer_done_o, wake_done_o})); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_done_o || wake_done_o || xfer_done_o) |=>
      !($past(sleep_done_o) && sleep_done_o) && !($past(wake_done_o) && wake_done_o)
      && !($past(xfer_done_o) && xfer_done_o)); // R9

endmodule

// File: tb/tb_pg_retention_seq.sv
module tb_pg_retention_seq;
  localparam int TMR_W = 24;
  localparam int LEN_W = 8;
  localparam logic [8:0] OBS_ON   = 9'b111000000;
  localparam logic [8:0] OBS_PD   = 9'b000001000;
  localparam logic [8:0] OBS_STAB = 9'b100001000;
  localparam logic [8:0] OBS_DIS  = 9'b000101000;
  localparam int NVEC = 10;
  // {limit[63:32], dis_len[31:24], osg_len[23:16], wake tick[15:0]}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'd0,     8'd2, 8'd2, 16'd20},
    {32'd6,     8'd2, 8'd3, 16'd40},
    {32'd2,     8'd1, 8'd1, 16'd30},
    {32'd6,     8'd2, 8'd3, 16'd2},
    {32'd6,     8'd4, 8'd2, 16'd9},
    {32'd6,     8'd2, 8'd3, 16'd7},
    {32'd5,     8'd0, 8'd0, 16'd25},
    {32'd100,   8'd3, 8'd3, 16'd60},
    {32'd10,    8'd1, 8'd2, 16'd14},
    {32'd0,     8'd1, 8'd1, 16'd20000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic wake_req = 1'b0;
  logic [TMR_W-1:0] limit = '0;
  logic [LEN_W-1:0] dis_len = 8'd1;
  logic [LEN_W-1:0] osg_len = 8'd1;
  logic pwr_en, dis_en, clk_en, ret_n, xfer, busy, sdone, xdone, wdone;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pg_retention_seq #(.TMR_W(TMR_W), .LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .limit_i(limit), .dis_len_i(dis_len), .osg_len_i(osg_len),
    .pwr_en_o(pwr_en), .dis_en_o(dis_en), .clk_en_o(clk_en), .retain_n_o(ret_n),
    .lt_xfer_o(xfer), .busy_o(busy), .sleep_done_o(sdone), .xfer_done_o(xdone),
    .wake_done_o(wdone)
  );

  wire [8:0] obs = {pwr_en, clk_en, ret_n, dis_en, xfer, busy, sdone, xdone, wdone};

  task automatic chk(input bit ok, input string tag, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  function automatic int wake_start(int l, int d, int x, int w);
    int de, xe, sd, xend;
    de = (d < 1) ? 1 : d;
    xe = (x < 1) ? 1 : x;
    sd = ((l > 3) ? l : 3) + 1;
    xend = sd + de + xe;
    if (w <= 3) return 4;
    if (l == 0 || w <= sd) return w;
    if (w <= xend) return xend + 1;
    return w;
  endfunction

  // tick-by-tick expectation from the requirements, k = ticks since sleep accept
  function automatic logic [8:0] model(int k, int l, int d, int x, int w);
    int de, xe, sd, xend, ws;
    bit lp;
    logic [8:0] r;
    de = (d < 1) ? 1 : d;
    xe = (x < 1) ? 1 : x;
    sd = ((l > 3) ? l : 3) + 1;
    xend = sd + de + xe;
    ws = wake_start(l, d, x, w);
    lp = (l != 0) && (w > sd);
    r = '0;
    if (k < 3) r = OBS_PD;
    else if (k < ws) begin
      if (k == 3) r[2] = 1'b1;
      if (lp && k >= sd && k < sd + de) r = OBS_DIS;
      else if (lp && k >= sd + de && k < xend) r = 9'b000011000;
      else if (lp && k == xend) r[1] = 1'b1;
    end
    else if (k < ws + 2) r = OBS_STAB;
    else if (k < ws + 4) r = 9'b110001000;
    else if (k < ws + 5) r = 9'b111001000;
    else begin
      r = OBS_ON;
      if (k == ws + 5) r[0] = 1'b1;
    end
    return r;
  endfunction

  task automatic run_vec(input int idx, input int l, input int d, input int x, input int w);
    bit okv;
    int kbad, kend;
    logic [8:0] gb, eb, e;
    okv = 1'b1; kbad = 0; gb = '0; eb = '0;
    limit = TMR_W'(l);
    dis_len = LEN_W'(d);
    osg_len = LEN_W'(x);
    kend = wake_start(l, d, x, w) + 6;
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    for (int k = 0; k <= kend; k++) begin
      e = model(k, l, d, x, w);
      if (obs !== e && okv) begin okv = 1'b0; kbad = k; gb = obs; eb = e; end
      wake_req = (k + 1 == w);
      @(negedge clk);
    end
    wake_req = 1'b0;
    chk(okv, $sformatf("R2 R3 R4 R5 R6 R7 R9 vec=%0d k=%0d", idx, kbad), gb, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(obs === OBS_ON, "R1 reset state", obs, OBS_ON);

    for (int i = 0; i < NVEC; i++)
      run_vec(i, int'(VEC[i][63:32]), int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:0]));

    // R8: wake while powered is ignored
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    chk(obs === OBS_ON, "R8 wake in powered state", obs, OBS_ON);
    @(negedge clk);
    chk(obs === OBS_ON, "R8 wake not held while powered", obs, OBS_ON);

    // R8: both requests together, sleep taken, wake dropped
    limit = '0;
    sleep_req = 1'b1; wake_req = 1'b1; @(negedge clk);
    sleep_req = 1'b0; wake_req = 1'b0;
    chk(obs === OBS_PD, "R8 sleep wins over wake", obs, OBS_PD);
    repeat (5) @(negedge clk);
    chk(obs === 9'b0, "R8 dropped wake not serviced", obs, 9'b0);
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0; @(negedge clk);
    chk(obs === 9'b0, "R8 sleep ignored while off", obs, 9'b0);

    // R6 wake from off, R8 repeated wake during wake-up ignored
    wake_req = 1'b1; @(negedge clk);
    chk(obs === OBS_STAB, "R6 supply first", obs, OBS_STAB);
    @(negedge clk); wake_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(obs === (OBS_ON | 9'b1), "R6 wake done at tick 5", obs, OBS_ON | 9'b1);
    @(negedge clk);
    chk(obs === OBS_ON, "R8 wake during wake-up not held", obs, OBS_ON);

    // R1: asynchronous reset during discharge
    limit = TMR_W'(4); dis_len = 8'd50; osg_len = 8'd1;
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    repeat (10) @(negedge clk);
    chk(obs === OBS_DIS, "R4 discharge active", obs, OBS_DIS);
    rst_n = 1'b0; #1;
    chk(obs === OBS_ON, "R1 async reset mid-discharge", obs, OBS_ON);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(obs === OBS_ON, "R1 powered after reset release", obs, OBS_ON);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule